// File: doc/BRIEF.md
# Multi-Hart Machine Timer Comparator

This block is a memory-mapped machine timer shared by the harts of a small multi-core cluster. A single 64-bit time counter advances by one on every clock cycle in which the tick-enable input is high. Each hart owns a 64-bit compare value. The hart's timer interrupt line stays high for as long as the counter is at or above that compare value.

Software reaches the registers over a 32-bit register bus. A request is a single-cycle pulse that carries the address, the write flag and the write data. The block answers every request with a ready pulse one cycle later, and read data is valid while ready is high. A 64-bit register is reached as two aligned 32-bit words, with the low word at the lower address. Each compare write is judged against the counter value of the same clock edge. A compare value that is already in the past therefore raises the interrupt at the edge that completes the write, and a value in the future lowers it at that same edge.

Top module: `hart_timer_cmp`

## Requirements
- R1: After reset every compare register and the time counter read zero, `bus_ready` is low, and every `timer_irq` bit is high, because a compare of zero is not in the future.
- R2: The time counter grows by exactly one at each rising clock edge where `tick_en` is high, and holds its value otherwise.
- R3: A read of `TIME_BASE` returns time bits 31:0 and a read of `TIME_BASE+4` returns bits 63:32. Writes to either word change nothing.
- R4: Hart h's compare register sits at `CMP_BASE+8*h`, with bits 31:0 at offset 0 and bits 63:32 at offset 4. Writing one word replaces only that half and keeps the other half. Both words read back the stored value.
- R5: A compare write that leaves the compare value less than or equal to the time value of that edge raises the hart's `timer_irq` at the same edge that raises `bus_ready`. This holds when the counter steps in that same cycle.
- R6: A compare write that leaves the compare value above the time value lowers the hart's `timer_irq` at the same edge. The line rises again at the edge where the counter reaches the compare value.
- R7: `timer_irq[h]` equals (time >= compare of hart h) at every cycle after reset. It stays high until the compare value is moved ahead of the counter.
- R8: A read of an offset that maps to no register returns zero. This covers compare slots with an index of `NUM_HARTS` or more and any address that is not 4-byte aligned. A write to such an offset changes no register and no interrupt line.
- R9: A request in cycle n yields `bus_ready` high in cycle n+1 only. `bus_rdata` is zero in the answer to a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter advance enable for this cycle |
| bus_req | input | 1 | Single-cycle access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the 32-bit word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_ready` is high |
| bus_ready | output | 1 | Access completion, one cycle after `bus_req` |
| timer_irq | output | NUM_HARTS | Per-hart timer interrupt level |

## Verification
A compare write and a counter step can land on the same clock edge. The interrupt level must then be judged against the advanced counter, not the old one. The bench provokes this by raising `tick_en` in the very cycle a compare write is issued. In one case the new compare value equals the old time plus one, so the line must be high at the answering edge. In the other case it equals the old time plus two, so the line must be low at that edge and rise at the next tick. Both outcomes are checked on the `timer_irq` port in the cycle of `bus_ready`.

// File: rtl/hart_timer_cmp.sv
module hart_timer_cmp #(
  parameter int unsigned NUM_HARTS = 2,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned CMP_BASE  = 'h4000,
  parameter int unsigned TIME_BASE = 'hBFF8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic                 bus_req,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 bus_ready,
  output logic [NUM_HARTS-1:0] timer_irq
);

  localparam int unsigned CMP_SPAN = 8 * NUM_HARTS;
  localparam logic [ADDR_W-1:0] T_LO = ADDR_W'(TIME_BASE);
  localparam logic [ADDR_W-1:0] T_HI = ADDR_W'(TIME_BASE + 4);
  localparam logic [ADDR_W-1:0] OOB  = ADDR_W'(CMP_BASE + CMP_SPAN);

  logic [63:0] mtime;
  logic [63:0] mtime_nxt;
  logic [NUM_HARTS-1:0][31:0] cmp_rd;
  logic [31:0] rd_word;
  logic [31:0] time_rd;

  wire wr = bus_req & bus_we;
  wire rd = bus_req & ~bus_we;

  assign mtime_nxt = mtime + {63'd0, tick_en};

  always_ff @(posedge clk) begin
    if (!rst_n) mtime <= '0;
    else        mtime <= mtime_nxt;
  end

  assign time_rd = (bus_addr == T_LO) ? mtime[31:0] :
                   (bus_addr == T_HI) ? mtime[63:32] : 32'd0;

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(CMP_BASE + 8 * h);
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(CMP_BASE + 8 * h + 4);
    logic [63:0] cmp_q;
    logic [63:0] cmp_nxt;
    logic        irq_q;

    always_comb begin
      cmp_nxt = cmp_q;
      if (wr && bus_addr == LO) cmp_nxt[31:0]  = bus_wdata;
      if (wr && bus_addr == HI) cmp_nxt[63:32] = bus_wdata;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cmp_q <= '0;
        irq_q <= 1'b1;
      end else begin
        cmp_q <= cmp_nxt;
        irq_q <= (mtime_nxt >= cmp_nxt);
      end
    end

    assign cmp_rd[h] = (bus_addr == LO) ? cmp_q[31:0] :
                       (bus_addr == HI) ? cmp_q[63:32] : 32'd0;
    assign timer_irq[h] = irq_q;

    p_irq_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q == (mtime >= cmp_q));
  end

  always_comb begin
    rd_word = time_rd;
    for (int h = 0; h < NUM_HARTS; h++) rd_word = rd_word | cmp_rd[h];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_ready <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ready <= bus_req;
      bus_rdata <= rd ? rd_word : 32'd0;
    end
  end

  p_ready_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> bus_ready);
  p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |=> !bus_ready);
  p_wr_rdata_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> bus_rdata == 32'd0);
  p_time_wr_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !tick_en && (bus_addr == T_LO || bus_addr == T_HI)) |=> $stable(mtime));
  p_oob_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_addr == OOB && OOB != T_LO && OOB != T_HI) |=> bus_rdata == 32'd0);

endmodule

// File: tb/test_hart_timer_cmp.sv
module test_hart_timer_cmp;
  localparam int CLK_PERIOD = 10;
  localparam int NH = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0;
  logic bus_req = 1'b0;
  logic bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_ready;
  logic [NH-1:0] timer_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  longint exp_time = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hart_timer_cmp #(.NUM_HARTS(NH), .ADDR_W(16), .CMP_BASE('h4000), .TIME_BASE('hBFF8))
    i_hart_timer_cmp (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_req(bus_req),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_ready(bus_ready), .timer_irq(timer_irq));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [15:0] a, input logic [31:0] d,
                        input bit tick, output logic [31:0] q);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d; tick_en = tick;
    @(negedge clk);
    bus_req = 1'b0; tick_en = 1'b0;
    if (tick) exp_time++;
    q = bus_rdata;
    check(bus_ready == 1'b1, "R9 ready", bus_ready, 1);
    if (we) check(bus_rdata == 0, "R9 write rdata", bus_rdata, 0);
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    logic [31:0] q;
    access(1'b1, a, d, 1'b0, q);
  endtask

  task automatic rd_chk(input logic [15:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] q;
    access(1'b0, a, 32'd0, 1'b0, q);
    check(q == exp, tag, q, exp);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n - 1) @(negedge clk);
    @(negedge clk);
    tick_en = 1'b0;
    exp_time += n;
    @(negedge clk);
    check(bus_ready == 1'b0, "R9 idle ready", bus_ready, 0);
  endtask

  task automatic t_reset();
    check(timer_irq == 2'b11, "R1 irq", timer_irq, 3);
    check(bus_ready == 1'b0, "R1 ready", bus_ready, 0);
    rd_chk(16'h4000, 0, "R1 cmp0 lo");
    rd_chk(16'h400C, 0, "R1 cmp1 hi");
    rd_chk(16'hBFF8, 0, "R1 time lo");
  endtask

  task automatic t_count();
    ticks(10);
    rd_chk(16'hBFF8, 32'(exp_time), "R2 time after 10 ticks");
    rd_chk(16'hBFF8, 32'(exp_time), "R2 time holds");
    rd_chk(16'hBFFC, 0, "R3 time hi");
    check(timer_irq == 2'b11, "R7 irq held", timer_irq, 3);
  endtask

  task automatic t_time_write();
    wr(16'hBFF8, 32'hDEAD);
    wr(16'hBFFC, 32'h5);
    rd_chk(16'hBFF8, 32'(exp_time), "R3 time lo unwritten");
    rd_chk(16'hBFFC, 0, "R3 time hi unwritten");
  endtask

  task automatic t_halves();
    wr(16'h400C, 32'h12345678);
    check(timer_irq[1] == 1'b0, "R6 irq1 drops", timer_irq[1], 0);
    wr(16'h4008, 32'hCAFEF00D);
    rd_chk(16'h400C, 32'h12345678, "R4 hi kept");
    rd_chk(16'h4008, 32'hCAFEF00D, "R4 lo written");
    rd_chk(16'h4000, 0, "R4 other hart untouched");
    wr(16'h400C, 32'h0);
    rd_chk(16'h4008, 32'hCAFEF00D, "R4 lo kept");
    check(timer_irq[1] == 1'b0, "R6 irq1 still future", timer_irq[1], 0);
  endtask

  task automatic t_past();
    wr(16'h4008, 32'd3);
    check(timer_irq[1] == 1'b1, "R5 past fires", timer_irq[1], 1);
    wr(16'h4008, 32'd100);
    check(timer_irq[1] == 1'b0, "R6 future clears", timer_irq[1], 0);
    wr(16'h4008, 32'(exp_time));
    check(timer_irq[1] == 1'b1, "R5 equal fires", timer_irq[1], 1);
  endtask

  task automatic t_future();
    wr(16'h4000, 32'(exp_time + 10));
    check(timer_irq[0] == 1'b0, "R6 irq0 clears", timer_irq[0], 0);
    ticks(9);
    check(timer_irq[0] == 1'b0, "R6 irq0 one short", timer_irq[0], 0);
    ticks(1);
    check(timer_irq[0] == 1'b1, "R6 irq0 reaches", timer_irq[0], 1);
    ticks(5);
    check(timer_irq == 2'b11, "R7 irq stays", timer_irq, 3);
  endtask

  task automatic t_unmapped();
    logic [31:0] c0;
    c0 = 32'(exp_time - 5);
    rd_chk(16'h4010, 0, "R8 beyond harts lo");
    rd_chk(16'h4014, 0, "R8 beyond harts hi");
    wr(16'h4010, 32'hFFFFFFFF);
    wr(16'h4014, 32'hFFFFFFFF);
    check(timer_irq == 2'b11, "R8 irq unchanged", timer_irq, 3);
    rd_chk(16'h4000, c0, "R8 cmp0 unchanged");
    rd_chk(16'h4001, 0, "R8 misaligned read");
    wr(16'h4006, 32'hFFFFFFFF);
    rd_chk(16'h4004, 0, "R8 misaligned write ignored");
    check(timer_irq[0] == 1'b1, "R8 irq0 unchanged", timer_irq[0], 1);
    rd_chk(16'h2000, 0, "R8 hole read");
  endtask

  task automatic t_same_cycle();
    logic [31:0] q;
    access(1'b1, 16'h4000, 32'(exp_time + 1), 1'b1, q);
    check(timer_irq[0] == 1'b1, "R5 write with tick meets", timer_irq[0], 1);
    access(1'b1, 16'h4000, 32'(exp_time + 2), 1'b1, q);
    check(timer_irq[0] == 1'b0, "R6 write with tick ahead", timer_irq[0], 0);
    ticks(1);
    check(timer_irq[0] == 1'b1, "R6 next tick reaches", timer_irq[0], 1);
    rd_chk(16'hBFF8, 32'(exp_time), "R2 time after mixed ticks");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_time_write();
    t_halves();
    t_past();
    t_future();
    t_unmapped();
    t_same_cycle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule